// File: doc/BRIEF.md
# Write-Protected Timer Protection Settings Bank

This block stores the safety-related settings of a PWM timer: a dead-time count, break enable and polarity, an automatic output-enable bit, two off-state selection bits, the idle output levels of normal and complementary outputs, and for every channel a direction, a compare mode, a preload enable and two output polarities. A simple synchronous port with a write strobe, an address, and write data updates the settings. The read data output shows the stored contents of the addressed word combinationally. Every field also leaves the block on its own output, for the counter, waveform and dead-time logic that sit next to it.

A 2-bit protection level guards the settings against stray software writes. Each higher level freezes a larger set of fields. Levels 2 and 3 act only on channels whose direction selects output, so input channels stay open. The level word itself takes a single write after reset. Protected bits of a write are dropped without any error, and the unprotected bits of the same word still update.

Top module: `tmr_prot_cfg`

## Requirements
- R1: After a synchronous active-low reset, every stored field is zero and the protection level is 00. All four words read 0.
- R2: The first write to address 0 after reset stores wdata[1:0] as the protection level. The level reads back at address 0, bits [1:0].
- R3: Every later write to address 0 is ignored until the next reset, including writes that repeat the same value.
- R4: At level 00, every field in addresses 1 to 3 takes the written value.
- R5: At level 01 or above, the following fields keep their value on a write:
  - the dead-time field (address 1, bits [7:0]);
  - break enable (address 1, bit 8);
  - break polarity (address 1, bit 9);
  - auto output enable (address 1, bit 10);
  - all idle levels (address 2: normal levels in bits [3:0], complementary levels in bits [7:4]).
- R6: At level 10 or above, the idle off-state bit (address 1, bit 11) and the run off-state bit (address 1, bit 12) also keep their value. So do both polarity bits of every output channel. Address 3 gives channel i the byte [8i+7:8i], laid out as follows: direction [1:0] (00 = output), mode [4:2], preload [5], polarity [6], complementary polarity [7].
- R7: At level 11, the mode and preload bits of every output channel also keep their value.
- R8: The stored direction before the write decides whether the channel-level protections apply. A channel whose direction is not 00 stays fully writable at every level. The direction field itself is never locked.
- R9: A write that touches protected bits still updates the unprotected bits of the same word.
- R10: The brk_en_o and brk_pol_o outputs change one clock after the stored value changes, which is two edges after the write is presented. Read-back at address 1 shows the new value after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Word select for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Contents of the addressed word |
| level_o | output | 2 | Current protection level |
| dead_time_o | output | 8 | Dead-time count |
| brk_en_o | output | 1 | Break enable, delayed one clock |
| brk_pol_o | output | 1 | Break polarity, delayed one clock |
| aoe_o | output | 1 | Automatic output enable |
| off_idle_o | output | 1 | Off-state select while outputs are disabled |
| off_run_o | output | 1 | Off-state select while outputs are enabled |
| idle_lvl_o | output | 4 | Idle level per normal output |
| idle_lvl_n_o | output | 4 | Idle level per complementary output |
| ch_dir_o | output | 8 | Direction per channel, 2 bits each |
| ch_mode_o | output | 12 | Compare mode per channel, 3 bits each |
| ch_pre_o | output | 4 | Preload enable per channel |
| ch_pol_o | output | 4 | Output polarity per channel |
| ch_pol_n_o | output | 4 | Complementary polarity per channel |

## Verification
A write is stored on the edge at which the strobe is seen. Read data is combinational, so the read-back is due in the cycle after that edge. The exported break bits are due one edge later still. The driver queues each expected value on the falling edge just before the rising edge whose result it predicts. The monitor pops one item a moment after every rising edge, which ties each compare to that exact cycle. For the break bits, the driver queues the old value for the first edge and the new value for the second edge.

// File: rtl/tmr_prot_pkg.sv
// Package: word selects and protection level encoding shared by the
// settings bank and its submodules. Assumes a 2-bit word address.
package tmr_prot_pkg;
    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_LVL  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_BRK  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_IDLE = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CHAN = 2'd3;
    localparam int CH_BYTE = 8;

    typedef enum logic [1:0] {
        PROT_NONE  = 2'b00,
        PROT_BASIC = 2'b01,
        PROT_POL   = 2'b10,
        PROT_FULL  = 2'b11
    } prot_lvl_e;
endpackage

// File: rtl/prot_level_reg.sv
// Module: holds the 2-bit protection level. Accepts exactly one write
// after reset; every later write is dropped until reset.
// Assumes: wr_hit is already qualified with the level word address.
module prot_level_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [1:0] wr_lvl,
    output logic [1:0] level_o
);
    logic [1:0] lvl_q;
    logic       taken_q;

    // Purpose: capture the first level write and mark the slot as used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 2'b00;
            taken_q <= 1'b0;
        end else if (wr_hit && !taken_q) begin
            lvl_q   <= wr_lvl;
            taken_q <= 1'b1;
        end
    end

    assign level_o = lvl_q;

    // R2: the first write lands in the level register
    a_r2_first_take: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !taken_q) |=> (lvl_q == $past(wr_lvl)));
    // R3: once taken, the level never moves before reset
    a_r3_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        taken_q |=> ($stable(lvl_q) && taken_q));
endmodule

// File: rtl/prot_mask_gen.sv
// Module: turns the protection level into three cumulative lock flags.
// Assumes: level encoding of tmr_prot_pkg; flags are combinational.
module prot_mask_gen
    import tmr_prot_pkg::*;
(
    input  logic [1:0] level_i,
    output logic       lock_base_o,
    output logic       lock_pol_o,
    output logic       lock_ctrl_o
);
    prot_lvl_e lvl;

    // Purpose: decode the level into nested lock groups.
    always_comb begin
        lvl         = prot_lvl_e'(level_i);
        lock_base_o = (lvl != PROT_NONE);
        lock_pol_o  = (lvl == PROT_POL) || (lvl == PROT_FULL);
        lock_ctrl_o = (lvl == PROT_FULL);
    end
endmodule

// File: rtl/chan_cfg_slot.sv
// Module: settings of one channel (direction, mode, preload, polarities).
// Polarity and control locks apply only while the stored direction is
// output (00); the direction field itself is always writable.
// Assumes: wr_hit is qualified with the channel word address.
module chan_cfg_slot
    import tmr_prot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [CH_BYTE-1:0] wbyte,
    input  logic               lock_pol,
    input  logic               lock_ctrl,
    output logic [1:0]         dir_o,
    output logic [2:0]         mode_o,
    output logic               pre_o,
    output logic               pol_o,
    output logic               pol_n_o,
    output logic [CH_BYTE-1:0] rbyte
);
    logic [1:0] dir_q;
    logic [2:0] mode_q;
    logic       pre_q, pol_q, pol_n_q;
    logic       is_out;

    assign is_out = (dir_q == 2'b00);

    // Purpose: apply a channel write, dropping locked bits of output channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= 2'b00;
            mode_q  <= 3'b000;
            pre_q   <= 1'b0;
            pol_q   <= 1'b0;
            pol_n_q <= 1'b0;
        end else if (wr_hit) begin
            dir_q <= wbyte[1:0];
            if (!(lock_ctrl && is_out)) begin
                mode_q <= wbyte[4:2];
                pre_q  <= wbyte[5];
            end
            if (!(lock_pol && is_out)) begin
                pol_q   <= wbyte[6];
                pol_n_q <= wbyte[7];
            end
        end
    end

    assign dir_o   = dir_q;
    assign mode_o  = mode_q;
    assign pre_o   = pre_q;
    assign pol_o   = pol_q;
    assign pol_n_o = pol_n_q;
    assign rbyte   = {pol_n_q, pol_q, pre_q, mode_q, dir_q};

    // R7: locked control fields of an output channel hold
    a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && lock_ctrl && is_out) |=> ($stable(mode_q) && $stable(pre_q)));
    // R6: locked polarities of an output channel hold
    a_r6_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && lock_pol && is_out) |=> ($stable(pol_q) && $stable(pol_n_q)));
    // R8: an input channel takes every written bit
    a_r8_input_open: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !is_out) |=> (rbyte == $past(wbyte)));
endmodule

// File: rtl/tmr_prot_cfg.sv
// Module: write-protected settings bank of a PWM timer. Holds dead time,
// break controls, off-state selects, idle levels and per-channel settings.
// A write-once protection level decides which bits a write may change.
// Assumes: one access per cycle; read data is combinational from addr.
module tmr_prot_cfg
    import tmr_prot_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DT_W   = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          level_o,
    output logic [DT_W-1:0]     dead_time_o,
    output logic                brk_en_o,
    output logic                brk_pol_o,
    output logic                aoe_o,
    output logic                off_idle_o,
    output logic                off_run_o,
    output logic [NCH-1:0]      idle_lvl_o,
    output logic [NCH-1:0]      idle_lvl_n_o,
    output logic [2*NCH-1:0]    ch_dir_o,
    output logic [3*NCH-1:0]    ch_mode_o,
    output logic [NCH-1:0]      ch_pre_o,
    output logic [NCH-1:0]      ch_pol_o,
    output logic [NCH-1:0]      ch_pol_n_o
);
    localparam int B_EN   = DT_W;
    localparam int B_POL  = DT_W + 1;
    localparam int B_AOE  = DT_W + 2;
    localparam int B_OIDL = DT_W + 3;
    localparam int B_ORUN = DT_W + 4;
    localparam int CH_W   = NCH * CH_BYTE;

    logic wr_lvl, wr_brk, wr_idle, wr_chan;
    logic lock_base, lock_pol, lock_ctrl;
    logic [DT_W-1:0] dt_q;
    logic brk_en_q, brk_pol_q, aoe_q, oidl_q, orun_q;
    logic brk_en_d1, brk_pol_d1;
    logic [NCH-1:0] idle_q, idle_n_q;
    logic [CH_W-1:0] chan_rd;

    // Purpose: qualify the write strobe per word.
    always_comb begin
        wr_lvl  = wr_en && (addr == SEL_LVL);
        wr_brk  = wr_en && (addr == SEL_BRK);
        wr_idle = wr_en && (addr == SEL_IDLE);
        wr_chan = wr_en && (addr == SEL_CHAN);
    end

    prot_level_reg u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_lvl),
        .wr_lvl  (wdata[1:0]),
        .level_o (level_o)
    );

    prot_mask_gen u_mask (
        .level_i     (level_o),
        .lock_base_o (lock_base),
        .lock_pol_o  (lock_pol),
        .lock_ctrl_o (lock_ctrl)
    );

    // Purpose: store the dead-time/break word, honouring both lock groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_q      <= '0;
            brk_en_q  <= 1'b0;
            brk_pol_q <= 1'b0;
            aoe_q     <= 1'b0;
            oidl_q    <= 1'b0;
            orun_q    <= 1'b0;
        end else if (wr_brk) begin
            if (!lock_base) begin
                dt_q      <= wdata[DT_W-1:0];
                brk_en_q  <= wdata[B_EN];
                brk_pol_q <= wdata[B_POL];
                aoe_q     <= wdata[B_AOE];
            end
            if (!lock_pol) begin
                oidl_q <= wdata[B_OIDL];
                orun_q <= wdata[B_ORUN];
            end
        end
    end

    // Purpose: one-clock lag on the exported break controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_en_d1  <= 1'b0;
            brk_pol_d1 <= 1'b0;
        end else begin
            brk_en_d1  <= brk_en_q;
            brk_pol_d1 <= brk_pol_q;
        end
    end

    // Purpose: store idle output levels unless the base lock is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q   <= '0;
            idle_n_q <= '0;
        end else if (wr_idle && !lock_base) begin
            idle_q   <= wdata[NCH-1:0];
            idle_n_q <= wdata[2*NCH-1:NCH];
        end
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        chan_cfg_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (wr_chan),
            .wbyte     (wdata[gi*CH_BYTE +: CH_BYTE]),
            .lock_pol  (lock_pol),
            .lock_ctrl (lock_ctrl),
            .dir_o     (ch_dir_o[gi*2 +: 2]),
            .mode_o    (ch_mode_o[gi*3 +: 3]),
            .pre_o     (ch_pre_o[gi]),
            .pol_o     (ch_pol_o[gi]),
            .pol_n_o   (ch_pol_n_o[gi]),
            .rbyte     (chan_rd[gi*CH_BYTE +: CH_BYTE])
        );
    end

    // Purpose: combinational read mux over the four words.
    always_comb begin
        rdata = '0;
        case (addr)
            SEL_LVL:  rdata[1:0] = level_o;
            SEL_BRK: begin
                rdata[DT_W-1:0] = dt_q;
                rdata[B_EN]     = brk_en_q;
                rdata[B_POL]    = brk_pol_q;
                rdata[B_AOE]    = aoe_q;
                rdata[B_OIDL]   = oidl_q;
                rdata[B_ORUN]   = orun_q;
            end
            SEL_IDLE: rdata[2*NCH-1:0] = {idle_n_q, idle_q};
            default:  rdata[CH_W-1:0] = chan_rd;
        endcase
    end

    assign dead_time_o  = dt_q;
    assign brk_en_o     = brk_en_d1;
    assign brk_pol_o    = brk_pol_d1;
    assign aoe_o        = aoe_q;
    assign off_idle_o   = oidl_q;
    assign off_run_o    = orun_q;
    assign idle_lvl_o   = idle_q;
    assign idle_lvl_n_o = idle_n_q;

    // R4: with no lock, the dead time follows the write
    a_r4_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_brk && !lock_base) |=> (dt_q == $past(wdata[DT_W-1:0])));
    // R5: the base lock freezes dead time, break bits and idle levels
    a_r5_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock_base) |=> ($stable(dt_q) && $stable(brk_en_q) &&
                                  $stable(aoe_q) && $stable(idle_q) && $stable(idle_n_q)));
    // R6: the polarity lock freezes both off-state bits
    a_r6_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_brk && lock_pol) |=> ($stable(oidl_q) && $stable(orun_q)));
    // R9: unlocked bits in a partly locked word still update
    a_r9_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_brk && lock_base && !lock_pol) |=> (orun_q == $past(wdata[B_ORUN])));
    // R10: an exported break bit moves only two edges after a write to its word
    a_r10_brk_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_en_o != $past(brk_en_o)) |-> $past(wr_en && (addr == SEL_BRK), 2));
endmodule

// File: tb/tmr_prot_cfg_tb_top.sv
module tmr_prot_cfg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  level_o;
    logic [7:0]  dead_time_o;
    logic        brk_en_o, brk_pol_o, aoe_o, off_idle_o, off_run_o;
    logic [3:0]  idle_lvl_o, idle_lvl_n_o, ch_pre_o, ch_pol_o, ch_pol_n_o;
    logic [7:0]  ch_dir_o;
    logic [11:0] ch_mode_o;

    typedef struct {
        int          kind;   // 0 rdata, 1 brk_en_o, 2 brk_pol_o
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_prot_cfg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .level_o(level_o), .dead_time_o(dead_time_o),
        .brk_en_o(brk_en_o), .brk_pol_o(brk_pol_o), .aoe_o(aoe_o),
        .off_idle_o(off_idle_o), .off_run_o(off_run_o),
        .idle_lvl_o(idle_lvl_o), .idle_lvl_n_o(idle_lvl_n_o),
        .ch_dir_o(ch_dir_o), .ch_mode_o(ch_mode_o), .ch_pre_o(ch_pre_o),
        .ch_pol_o(ch_pol_o), .ch_pol_n_o(ch_pol_n_o)
    );

    // monitor: one expected item per rising edge, sampled shortly after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    1:       act = {31'd0, brk_en_o};
                    2:       act = {31'd0, brk_pol_o};
                    default: act = rdata;
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called on a falling edge: queue the read result for the next rising edge
    task automatic expect_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        addr = a;
        q.push_back('{0, e, tag});
        @(negedge clk);
    endtask

    task automatic program_all();
        wr(2'd1, 32'h0000_1F5A);
        wr(2'd2, 32'h0000_00A5);
        wr(2'd3, 32'h7978_7878);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset contents
        for (int i = 0; i < 4; i++) expect_rd(2'(i), 32'h0, "R1");
        q.push_back('{1, 32'h0, "R1"});
        @(negedge clk);

        // R10: break bits lag the stored value by one clock
        wr_en = 1'b1; addr = 2'd1; wdata = 32'h0000_1F5A;
        q.push_back('{1, 32'h0, "R10"});
        @(negedge clk);
        wr_en = 1'b0;
        q.push_back('{1, 32'h1, "R10"});
        @(negedge clk);
        q.push_back('{2, 32'h1, "R10"});
        @(negedge clk);

        // R4: level 00 leaves every field open
        expect_rd(2'd1, 32'h0000_1F5A, "R4");
        wr(2'd2, 32'h0000_00A5);
        expect_rd(2'd2, 32'h0000_00A5, "R4");
        wr(2'd3, 32'h7978_7878);
        expect_rd(2'd3, 32'h7978_7878, "R4");

        // R2 / R3: level written once
        wr(2'd0, 32'h1);
        expect_rd(2'd0, 32'h1, "R2");
        wr(2'd0, 32'h3);
        expect_rd(2'd0, 32'h1, "R3");

        // level 01: base group locked, off-state bits still open (R5 R9)
        wr(2'd1, 32'h0);
        expect_rd(2'd1, 32'h0000_075A, "R5 R9");
        wr(2'd2, 32'h0);
        expect_rd(2'd2, 32'h0000_00A5, "R5");
        q.push_back('{1, 32'h1, "R5"});
        @(negedge clk);
        wr(2'd3, 32'h0100_0000);
        expect_rd(2'd3, 32'h0100_0000, "R6");

        // level 10
        do_reset();
        expect_rd(2'd0, 32'h0, "R3");
        program_all();
        wr(2'd0, 32'h2);
        expect_rd(2'd0, 32'h2, "R2");
        wr(2'd1, 32'h0);
        expect_rd(2'd1, 32'h0000_1F5A, "R6");
        wr(2'd3, 32'h0);
        expect_rd(2'd3, 32'h0040_4040, "R6 R8");

        // level 11
        do_reset();
        program_all();
        wr(2'd0, 32'h3);
        wr(2'd3, 32'h0);
        expect_rd(2'd3, 32'h0078_7878, "R7 R8");
        wr(2'd2, 32'hFF);
        expect_rd(2'd2, 32'h0000_00A5, "R5");
        wr(2'd0, 32'h0);
        expect_rd(2'd0, 32'h3, "R3");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule